// File: doc/BRIEF.md
# I2C Bus Unstick Sequencer

This block frees an I2C bus that a target device holds stuck, typically with SDA pinned low in the middle of a byte. A pulse on the trigger input makes the block take over both bus lines through an override path. It first clocks SCL nine times while leaving SDA released, so that any target part-way through a byte can shift out its remaining bits and let go of SDA. It then builds a stop condition by hand, one pin step at a time.

Every step lasts one half-period. The half-period is a count of system clocks, read from an input when the sequence starts. On the last clock of the final step the block samples SDA. It then raises a one-cycle done pulse and a busy flag that stays set until the next accepted trigger. Busy is set only when SDA was still low at that sample. Both lines use open-drain semantics: a pull output of 1 drives the line low, and 0 releases it to the pull-up.

A bus controller triggers this block when SDA has not gone free within a short wait before a transfer. Ordinary transfers and detecting a stuck bus are left to other logic.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `ovr_active`, `done` and `busy` are all 0.
- R2: When `kick` is 1 at a clock edge while the block is idle, the sequence is accepted. From the next cycle, `ovr_active` is 1 and both pull outputs are 0.
- R3: The flush phase is nine pulses, each 2·H cycles long, where H is the effective half-period. In each pulse SCL is released (`scl_pull`=0) for H cycles and then pulled (`scl_pull`=1) for H cycles. `sda_pull` is 0 for the whole flush.
- R4: After the flush come four steps of H cycles each, encoded as {scl_pull, sda_pull}: 10, then 11, then 01, then 00. SDA only begins to be pulled while SCL is already held low.
- R5: `ovr_active` stays 1 for exactly 22·H cycles. In the cycle after the last one, `done` is 1 for one cycle and `ovr_active` is 0.
- R6: `busy` takes the inverse of `sda_in` as seen on the last cycle of the final stop step, so it is 1 if SDA was still low. It becomes visible together with `done`, holds until the next accepted trigger, and is cleared in the cycle after that trigger.
- R7: A `kick` that arrives while `ovr_active` is 1 is ignored: the running sequence neither restarts nor changes length.
- R8: `half_ticks` is latched when the sequence is accepted. Changing it later has no effect on the running sequence.
- R9: A `half_ticks` value of 0 is treated as 1.
- R10: When `ovr_active` is 0, both pull outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Request to start a recovery sequence |
| half_ticks | input | CNT_W | Half-period in system clocks (0 behaves as 1) |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| ovr_active | output | 1 | Override path owns the pins |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| busy | output | 1 | SDA was still low at the final sample |

## Verification
Some properties hold on every cycle, and the assertions check them there. Idle pins stay released. Done is a single pulse that follows the end of activity. The step index moves only at step boundaries, which a stray trigger cannot change. SDA is never pulled down while SCL is released, and SDA is released while SCL is high to form the stop edge. Busy changes only at done or just after a start. What needs the bench's scenarios is the exact per-cycle pin waveform for each half-period, including the latched and zero half-periods. The same holds for the total length under a trigger held high, and for the pass/fail verdict with a healthy bus versus a bus stuck low.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FLUSH = 2'd1,
    PH_STOP  = 2'd2
  } phase_e;

  typedef struct packed {
    logic scl_pull;
    logic sda_pull;
  } pins_t;

  localparam int unsigned STOP_STEPS = 4;

  // Flush pulse: SCL released in the first half, pulled in the second.
  function automatic pins_t flush_pins(input logic second_half);
    pins_t p;
    p.scl_pull = second_half;
    p.sda_pull = 1'b0;
    return p;
  endfunction

  // Hand-built stop: SCL low, then SDA low, then SCL up, then SDA up.
  function automatic pins_t stop_pins(input logic [1:0] idx);
    pins_t p;
    case (idx)
      2'd0:    p = '{scl_pull: 1'b1, sda_pull: 1'b0};
      2'd1:    p = '{scl_pull: 1'b1, sda_pull: 1'b1};
      2'd2:    p = '{scl_pull: 1'b0, sda_pull: 1'b1};
      default: p = '{scl_pull: 1'b0, sda_pull: 1'b0};
    endcase
    return p;
  endfunction

  // Number of active cycles for a given pulse count and effective half-period.
  function automatic int unsigned run_cycles(input int unsigned pulses,
                                             input int unsigned half_eff);
    return (2 * pulses + STOP_STEPS) * half_eff;
  endfunction

endpackage

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] half_in,
  input  logic             run,
  output logic             step_end
);

  function automatic logic [CNT_W-1:0] eff_half(input logic [CNT_W-1:0] h);
    return (h == '0) ? CNT_W'(1) : h;
  endfunction

  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= CNT_W'(1);
      cnt_q  <= '0;
    end else if (load) begin
      half_q <= eff_half(half_in);
      cnt_q  <= eff_half(half_in) - CNT_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= half_q - CNT_W'(1);
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign step_end = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_unstick_stepper.sv
module i2c_unstick_stepper
  import i2c_unstick_pkg::*;
#(
  parameter int unsigned PULSES = 9,
  parameter int unsigned IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             step_end,
  output phase_e           phase,
  output logic [IDX_W-1:0] step_idx,
  output logic             accept,
  output logic             last_end,
  output logic             running,
  output logic             done
);

  localparam int unsigned FLUSH_STEPS = 2 * PULSES;

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign accept   = kick && (phase_q == PH_IDLE);
  assign running  = (phase_q != PH_IDLE);
  assign last_end = step_end && (phase_q == PH_STOP) &&
                    (idx_q == IDX_W'(STOP_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_end;
      if (accept) begin
        phase_q <= PH_FLUSH;
        idx_q   <= '0;
      end else if (step_end) begin
        case (phase_q)
          PH_FLUSH: begin
            if (idx_q == IDX_W'(FLUSH_STEPS - 1)) begin
              phase_q <= PH_STOP;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          PH_STOP: begin
            if (idx_q == IDX_W'(STOP_STEPS - 1)) begin
              phase_q <= PH_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          default: begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
          end
        endcase
      end
    end
  end

  assign phase    = phase_q;
  assign step_idx = idx_q;
  assign done     = done_q;

endmodule

// File: rtl/i2c_unstick_pinmap.sv
module i2c_unstick_pinmap
  import i2c_unstick_pkg::*;
(
  input  phase_e     phase,
  input  logic [1:0] idx_lo,
  output logic       scl_pull,
  output logic       sda_pull
);

  pins_t pins;

  always_comb begin
    case (phase)
      PH_FLUSH: pins = flush_pins(idx_lo[0]);
      PH_STOP:  pins = stop_pins(idx_lo);
      default:  pins = '{scl_pull: 1'b0, sda_pull: 1'b0};
    endcase
  end

  assign scl_pull = pins.scl_pull;
  assign sda_pull = pins.sda_pull;

endmodule

// File: rtl/i2c_unstick_verdict.sv
module i2c_unstick_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic sda_in,
  output logic busy
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (clear)  busy_q <= 1'b0;
    else if (sample) busy_q <= !sda_in;
  end

  assign busy = busy_q;

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [CNT_W-1:0] half_ticks,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             ovr_active,
  output logic             done,
  output logic             busy
);

  localparam int unsigned FLUSH_STEPS = 2 * PULSES;
  localparam int unsigned IDX_W = (FLUSH_STEPS > 4) ? $clog2(FLUSH_STEPS) : 2;

  // Named internal events, observed by the bound checker.
  phase_e           phase_w;
  logic [IDX_W-1:0] step_idx_w;
  logic             accept_w;
  logic             step_end_w;
  logic             last_end_w;
  logic             running_w;

  i2c_unstick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_w),
    .half_in  (half_ticks),
    .run      (running_w),
    .step_end (step_end_w)
  );

  i2c_unstick_stepper #(.PULSES(PULSES), .IDX_W(IDX_W)) u_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .step_end (step_end_w),
    .phase    (phase_w),
    .step_idx (step_idx_w),
    .accept   (accept_w),
    .last_end (last_end_w),
    .running  (running_w),
    .done     (done)
  );

  i2c_unstick_pinmap u_pinmap (
    .phase    (phase_w),
    .idx_lo   (step_idx_w[1:0]),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
  );

  i2c_unstick_verdict u_verdict (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept_w),
    .sample (last_end_w),
    .sda_in (sda_in),
    .busy   (busy)
  );

  assign ovr_active = running_w;

endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             step_end,
  input logic [IDX_W-1:0] step_idx,
  input logic             ovr_active,
  input logic             scl_pull,
  input logic             sda_pull,
  input logic             done,
  input logic             busy
);

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_active |-> (!scl_pull && !sda_pull));

  // R2
  start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ovr_active && !scl_pull && !sda_pull));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ovr_active && $past(ovr_active)));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_active && !step_end) |=> $stable(step_idx));

  // R4
  sda_low_under_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (scl_pull && $past(scl_pull)));

  // R4
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_active && $fell(sda_pull)) |-> !scl_pull);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(accept)) |-> $stable(busy));

endmodule

bind i2c_unstick i2c_unstick_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept_w),
  .step_end   (step_end_w),
  .step_idx   (step_idx_w),
  .ovr_active (ovr_active),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .done       (done),
  .busy       (busy)
);

// File: tb/i2c_unstick_bench.sv
module i2c_unstick_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             kick = 1'b0;
  logic [CNT_W-1:0] half_ticks = '0;
  logic             stuck = 1'b0;
  logic             sda_in;
  logic             scl_pull, sda_pull, ovr_active, done, busy;

  always #5 clk = ~clk;

  // Open-drain SDA line: low when the block pulls it or a target holds it.
  assign sda_in = !sda_pull && !stuck;

  i2c_unstick u_i2c_unstick (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick       (kick),
    .half_ticks (half_ticks),
    .sda_in     (sda_in),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .ovr_active (ovr_active),
    .done       (done),
    .busy       (busy)
  );

  int errors = 0;
  int checks = 0;
  int act_cnt = 0;
  int cyc_cnt = 0;

  // Reference model: queue of expected {stop, scl_pull, sda_pull} per active cycle.
  logic [2:0] exp_q[$];
  logic       exp_done = 1'b0;
  logic       exp_busy = 1'b0;
  logic       p_kick, p_sda, p_rst;
  int         p_half;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc_cnt);
    end
  endtask

  task automatic model_step();
    if (!p_rst) begin
      exp_q.delete();
      exp_done = 1'b0;
      exp_busy = 1'b0;
    end else if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      if (exp_q.size() == 0) begin
        exp_done = 1'b1;
        exp_busy = !p_sda;
      end else begin
        exp_done = 1'b0;
      end
    end else begin
      exp_done = 1'b0;
      if (p_kick) begin
        int he;
        he = (p_half == 0) ? 1 : p_half;
        exp_busy = 1'b0;
        for (int p = 0; p < 9; p++) begin
          for (int k = 0; k < he; k++) exp_q.push_back(3'b000);
          for (int k = 0; k < he; k++) exp_q.push_back(3'b010);
        end
        for (int k = 0; k < he; k++) exp_q.push_back(3'b110);
        for (int k = 0; k < he; k++) exp_q.push_back(3'b111);
        for (int k = 0; k < he; k++) exp_q.push_back(3'b101);
        for (int k = 0; k < he; k++) exp_q.push_back(3'b100);
      end
    end
  endtask

  task automatic compare();
    if (exp_q.size() > 0) begin
      string r;
      r = exp_q[0][2] ? "R4" : "R3";
      check(r, "ovr_active", int'(ovr_active), 1);
      check(r, "scl_pull", int'(scl_pull), int'(exp_q[0][1]));
      check(r, "sda_pull", int'(sda_pull), int'(exp_q[0][0]));
    end else begin
      check("R10", "ovr_active", int'(ovr_active), 0);
      check("R10", "pulls", int'({scl_pull, sda_pull}), 0);
    end
    check("R5", "done", int'(done), int'(exp_done));
    check("R6", "busy", int'(busy), int'(exp_busy));
  endtask

  // One clock: inputs are held across the edge, outputs sampled at the next falling edge.
  task automatic cyc();
    p_kick = kick;
    p_half = int'(half_ticks);
    p_sda  = !sda_pull && !stuck;
    p_rst  = rst_n;
    @(posedge clk);
    @(negedge clk);
    cyc_cnt++;
    if (ovr_active) act_cnt++;
    model_step();
    compare();
  endtask

  // Start a sequence, optionally change inputs mid-run, wait for done, check length.
  task automatic run_seq(input int h, input logic stk, input logic hold_kick,
                         input int h_mid, input int exp_len, input string req);
    int guard;
    half_ticks = CNT_W'(h);
    stuck = stk;
    kick = 1'b1;
    act_cnt = 0;
    cyc();
    // R2: first cycle after acceptance releases both lines
    check("R2", "start pins", int'({ovr_active, scl_pull, sda_pull}), 3'b100);
    kick = hold_kick;
    if (h_mid >= 0) half_ticks = CNT_W'(h_mid);
    guard = 0;
    while (!done && guard < 2000) begin
      cyc();
      guard++;
    end
    kick = 1'b0;
    check(req, "active length", act_cnt, exp_len);
    check("R5", "done after run", int'({done, ovr_active}), 2'b10);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    check("R1", "outputs after reset",
          int'({scl_pull, sda_pull, ovr_active, done, busy}), 0);

    // Healthy bus, H=3: 66 active cycles, no busy (R3, R4, R5, R6)
    run_seq(3, 1'b0, 1'b0, -1, 66, "R5");
    check("R6", "busy healthy", int'(busy), 0);
    repeat (4) cyc();

    // Stuck bus, H=1: busy set and held while idle (R6)
    run_seq(1, 1'b1, 1'b0, -1, 22, "R5");
    check("R6", "busy stuck", int'(busy), 1);
    stuck = 1'b0;
    repeat (5) cyc();
    check("R6", "busy held", int'(busy), 1);

    // Trigger held high throughout run, H=2: no restart (R7); busy cleared at start (R6)
    run_seq(2, 1'b0, 1'b1, -1, 44, "R7");
    check("R6", "busy cleared", int'(busy), 0);
    repeat (3) cyc();
    while (ovr_active) cyc();
    repeat (2) cyc();

    // Half-period changed after start (R8)
    run_seq(4, 1'b0, 1'b0, 1, 88, "R8");
    repeat (2) cyc();

    // Zero half-period behaves as one (R9)
    run_seq(0, 1'b0, 1'b0, -1, 22, "R9");
    repeat (3) cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule